// File: doc/BRIEF.md
# Interleaved Three-Channel Timer Register Bank

This block is the bus-facing register file for a group of three timer channels that share one address window. The window is organised by register kind: every kind of register has a run of three adjacent 32-bit words, and the word at +0, +4 or +8 inside that run belongs to channel 0, 1 or 2. The channel of any word is therefore its word index modulo three, and the register kind is the word index divided by three.

A host issues single-cycle read or write strobes with a byte offset. Written data is trimmed to the width of the target field, and the stored values drive each channel core directly. The cores report their live 16-bit count and event-width value back into the block for reading. They raise interrupt causes through per-channel set pulses. The block keeps a sticky status word per channel that clears when it is read, gates it with a per-channel enable mask, and drives one interrupt line per channel. A counter-control write with the restart bit set produces a one-cycle restart pulse to that channel's core instead of storing the bit.

The reset deassertion of `rst_n` is expected to be already synchronised to `clk` by the surrounding logic. Read data is registered and holds its value between reads.

Top module: `tmr3_regbank`

## Requirements
- R1: The byte offset `kind*12 + chan*4` selects register kind `kind` of channel `chan`. The kinds are numbered 0 clock setup, 1 counter control, 2 count value, 3 interval, 4 to 6 compare values one to three, 7 interrupt status, 8 interrupt enable, 9 event setup and 10 event value. Compare value `m` of channel `c` appears on `match` bits `(c*3+m)*16` upward.
- R2: After reset, counter control reads 0x21 on every channel and appears as 0x21 on `cnt_ctrl`. Every other stored field reads zero, and every `irq` line is low.
- R3: Writes keep only the low 6 bits for clock setup and interrupt enable, the low 16 bits for interval and compare values, and the low 3 bits for event setup. Counter control keeps the low 6 bits with bit 4 stored as zero.
- R4: A counter-control write with data bit 4 set raises that channel's `cnt_rst` bit for exactly one cycle, in the cycle after the write strobe.
- R5: A read of the count value returns that channel's `cnt_val` as sampled in the read cycle, zero-extended. Writes to it have no effect.
- R6: A read of the event value returns that channel's `evt_val`, zero-extended. Writes to it have no effect.
- R7: Each bit of a channel's `irq_set` field latches into that channel's status word. The channel's `irq` line is high whenever its status word ANDed with its enable mask is non-zero.
- R8: A read of a channel's interrupt status returns the status word and clears it in the same access, and only for that channel. A set pulse that arrives in the read cycle is kept for the next read.
- R9: Writes to an interrupt status word change neither the status nor `irq`.
- R10: Reads of offsets above 0x80 or not word-aligned return zero. Writes to such offsets change no output.
- R11: `rdata` updates only in the cycle after `rd_en` and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, synchronously released |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset into the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cnt_val | input | 3*CNT_W | Live count of each channel |
| evt_val | input | 3*CNT_W | Event-width value of each channel |
| irq_set | input | 18 | Interrupt cause pulses, 6 per channel |
| clk_ctrl | output | 18 | Clock setup, 6 per channel |
| cnt_ctrl | output | 18 | Counter control, 6 per channel |
| intv | output | 3*CNT_W | Interval value per channel |
| match | output | 9*CNT_W | Three compare values per channel |
| irq_en | output | 18 | Interrupt enable mask per channel |
| evt_ctrl | output | 9 | Event setup, 3 per channel |
| cnt_rst | output | 3 | One-cycle restart pulse per channel |
| irq | output | 3 | Interrupt line per channel |

## Verification
A decode fault that maps a word to the wrong channel shows at the ports one cycle after the write. It appears as a neighbouring channel's output field changing, or as a read-back in the next read that returns a neighbour's value. A status word that fails to clear, or clears the wrong channel, keeps `irq` high after the read and returns stale flags on the next read of that address. A lost set pulse in the read cycle only becomes visible on the following status read. For that reason the bench reads status twice around coincident events.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int NCH      = 3;
  localparam int NMATCH   = 3;
  localparam int NKIND    = 11;
  localparam int CLK_W    = 6;
  localparam int CTRL_W   = 6;
  localparam int IRQ_W    = 6;
  localparam int ECTL_W   = 3;
  localparam int RESTART_BIT = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 6'h21;

  typedef enum logic [3:0] {
    K_CLK  = 4'd0,
    K_CTRL = 4'd1,
    K_VAL  = 4'd2,
    K_INTV = 4'd3,
    K_M1   = 4'd4,
    K_M2   = 4'd5,
    K_M3   = 4'd6,
    K_STAT = 4'd7,
    K_IEN  = 4'd8,
    K_ECTL = 4'd9,
    K_EVT  = 4'd10
  } kind_e;
endpackage

// File: rtl/tmr3_addr_dec.sv
module tmr3_addr_dec
  import tmr3_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output kind_e             kind,
  output logic [1:0]        chan
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] NCH_V   = WORD_W'(NCH);
  localparam logic [WORD_W-1:0] NKIND_V = WORD_W'(NKIND);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] quot;

  always_comb begin
    word = addr[ADDR_W-1:2];
    quot = word / NCH_V;
    hit  = (addr[1:0] == 2'b00) && (quot < NKIND_V);
    kind = hit ? kind_e'(4'(quot)) : K_CLK;
    chan = 2'(word - quot * NCH_V);
  end
endmodule

// File: rtl/tmr3_chan_regs.sv
module tmr3_chan_regs
  import tmr3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_hit,
  input  logic                    rd_hit,
  input  kind_e                   kind,
  input  logic [CNT_W-1:0]        wdata,
  input  logic [IRQ_W-1:0]        irq_set,
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic [CNT_W-1:0]        evt_val,
  output logic [CLK_W-1:0]        clk_ctrl,
  output logic [CTRL_W-1:0]       cnt_ctrl,
  output logic [CNT_W-1:0]        intv,
  output logic [NMATCH*CNT_W-1:0] match,
  output logic [IRQ_W-1:0]        irq_en,
  output logic [ECTL_W-1:0]       evt_ctrl,
  output logic                    cnt_rst,
  output logic                    irq,
  output logic [31:0]             rd_word
);
  localparam logic [CTRL_W-1:0] CTRL_KEEP = ~(CTRL_W'(1) << RESTART_BIT);

  logic [CLK_W-1:0]  clk_q,  clk_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  intv_q, intv_d;
  logic [CNT_W-1:0]  mt_q [NMATCH];
  logic [CNT_W-1:0]  mt_d [NMATCH];
  logic [IRQ_W-1:0]  ien_q,  ien_d;
  logic [ECTL_W-1:0] ectl_q, ectl_d;
  logic [IRQ_W-1:0]  stat_q, stat_d;
  logic              rst_q,  rst_d;
  logic              stat_clr;

  // next state
  always_comb begin
    clk_d  = clk_q;
    ctrl_d = ctrl_q;
    intv_d = intv_q;
    ien_d  = ien_q;
    ectl_d = ectl_q;
    rst_d  = 1'b0;
    for (int m = 0; m < NMATCH; m++) mt_d[m] = mt_q[m];
    stat_clr = rd_hit && (kind == K_STAT);
    stat_d   = (stat_clr ? '0 : stat_q) | irq_set;
    if (wr_hit) begin
      case (kind)
        K_CLK:  clk_d  = wdata[CLK_W-1:0];
        K_CTRL: begin
          ctrl_d = wdata[CTRL_W-1:0] & CTRL_KEEP;
          rst_d  = wdata[RESTART_BIT];
        end
        K_INTV: intv_d = wdata;
        K_IEN:  ien_d  = wdata[IRQ_W-1:0];
        K_ECTL: ectl_d = wdata[ECTL_W-1:0];
        default: ;
      endcase
      for (int m = 0; m < NMATCH; m++) begin
        if (kind == kind_e'(4'(int'(K_M1) + m))) mt_d[m] = wdata;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      ctrl_q <= CTRL_RST_VAL;
      intv_q <= '0;
      ien_q  <= '0;
      ectl_q <= '0;
      stat_q <= '0;
      rst_q  <= 1'b0;
      for (int m = 0; m < NMATCH; m++) mt_q[m] <= '0;
    end else begin
      clk_q  <= clk_d;
      ctrl_q <= ctrl_d;
      intv_q <= intv_d;
      ien_q  <= ien_d;
      ectl_q <= ectl_d;
      stat_q <= stat_d;
      rst_q  <= rst_d;
      for (int m = 0; m < NMATCH; m++) mt_q[m] <= mt_d[m];
    end
  end

  // read word for this channel, selected by register kind
  always_comb begin
    rd_word = '0;
    case (kind)
      K_CLK:  rd_word = 32'(clk_q);
      K_CTRL: rd_word = 32'(ctrl_q);
      K_VAL:  rd_word = 32'(cnt_val);
      K_INTV: rd_word = 32'(intv_q);
      K_STAT: rd_word = 32'(stat_q);
      K_IEN:  rd_word = 32'(ien_q);
      K_ECTL: rd_word = 32'(ectl_q);
      K_EVT:  rd_word = 32'(evt_val);
      default: ;
    endcase
    for (int m = 0; m < NMATCH; m++) begin
      if (kind == kind_e'(4'(int'(K_M1) + m))) rd_word = 32'(mt_q[m]);
    end
  end

  generate
    for (genvar m = 0; m < NMATCH; m++) begin : g_mt
      assign match[m*CNT_W +: CNT_W] = mt_q[m];
    end
  endgenerate

  assign clk_ctrl = clk_q;
  assign cnt_ctrl = ctrl_q;
  assign intv     = intv_q;
  assign irq_en   = ien_q;
  assign evt_ctrl = ectl_q;
  assign cnt_rst  = rst_q;
  assign irq      = |(stat_q & ien_q);
endmodule

// File: rtl/tmr3_regbank.sv
module tmr3_regbank
  import tmr3_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic [NCH*CNT_W-1:0]        cnt_val,
  input  logic [NCH*CNT_W-1:0]        evt_val,
  input  logic [NCH*IRQ_W-1:0]        irq_set,
  output logic [NCH*CLK_W-1:0]        clk_ctrl,
  output logic [NCH*CTRL_W-1:0]       cnt_ctrl,
  output logic [NCH*CNT_W-1:0]        intv,
  output logic [NCH*NMATCH*CNT_W-1:0] match,
  output logic [NCH*IRQ_W-1:0]        irq_en,
  output logic [NCH*ECTL_W-1:0]       evt_ctrl,
  output logic [NCH-1:0]              cnt_rst,
  output logic [NCH-1:0]              irq
);
  logic        hit;
  kind_e       kind;
  logic [1:0]  chan;
  logic [31:0] rd_word [NCH];
  logic [31:0] rdata_q, rdata_d;
  logic        unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:CNT_W];

  tmr3_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
    .addr (addr),
    .hit  (hit),
    .kind (kind),
    .chan (chan)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel = hit && (chan == 2'(c));

      tmr3_chan_regs #(.CNT_W(CNT_W)) i_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && sel),
        .rd_hit   (rd_en && sel),
        .kind     (kind),
        .wdata    (wdata[CNT_W-1:0]),
        .irq_set  (irq_set[c*IRQ_W +: IRQ_W]),
        .cnt_val  (cnt_val[c*CNT_W +: CNT_W]),
        .evt_val  (evt_val[c*CNT_W +: CNT_W]),
        .clk_ctrl (clk_ctrl[c*CLK_W +: CLK_W]),
        .cnt_ctrl (cnt_ctrl[c*CTRL_W +: CTRL_W]),
        .intv     (intv[c*CNT_W +: CNT_W]),
        .match    (match[c*NMATCH*CNT_W +: NMATCH*CNT_W]),
        .irq_en   (irq_en[c*IRQ_W +: IRQ_W]),
        .evt_ctrl (evt_ctrl[c*ECTL_W +: ECTL_W]),
        .cnt_rst  (cnt_rst[c]),
        .irq      (irq[c]),
        .rd_word  (rd_word[c])
      );
    end
  endgenerate

  // read data next state: selected channel word, zero when unmapped
  always_comb begin
    rdata_d = '0;
    if (hit) begin
      for (int c = 0; c < NCH; c++) begin
        if (chan == 2'(c)) rdata_d = rd_word[c];
      end
    end
  end

  // read data register, enabled by the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tmr3_regbank_chk.sv
module tmr3_regbank_chk
  import tmr3_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [31:0]                 wdata,
  input logic [31:0]                 rdata,
  input logic [NCH*CNT_W-1:0]        cnt_val,
  input logic [NCH*CNT_W-1:0]        evt_val,
  input logic [NCH*IRQ_W-1:0]        irq_set,
  input logic [NCH*CLK_W-1:0]        clk_ctrl,
  input logic [NCH*CTRL_W-1:0]       cnt_ctrl,
  input logic [NCH*CNT_W-1:0]        intv,
  input logic [NCH*NMATCH*CNT_W-1:0] match,
  input logic [NCH*IRQ_W-1:0]        irq_en,
  input logic [NCH*ECTL_W-1:0]       evt_ctrl,
  input logic [NCH-1:0]              cnt_rst,
  input logic [NCH-1:0]              irq
);
  localparam logic [ADDR_W-1:0] LAST_OFS  = ADDR_W'(NKIND*NCH*4 - 4);
  localparam logic [ADDR_W-1:0] STAT_LO   = ADDR_W'(int'(K_STAT)*NCH*4);
  localparam logic [ADDR_W-1:0] STAT_HI   = ADDR_W'(int'(K_STAT)*NCH*4 + 8);

  logic [NCH-1:0] any_en;
  logic           unmapped;
  logic           stat_addr;

  always_comb begin
    for (int c = 0; c < NCH; c++) any_en[c] = |irq_en[c*IRQ_W +: IRQ_W];
    unmapped  = (addr[1:0] != 2'b00) || (addr > LAST_OFS);
    stat_addr = (addr[1:0] == 2'b00) && (addr >= STAT_LO) && (addr <= STAT_HI);
  end

  a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_rst));

  a_r4_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst != '0) |-> ($past(wr_en) && $past(wdata[RESTART_BIT])));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~any_en) == '0);

  a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && stat_addr && irq_set == '0) |=> $stable(irq));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == 32'h0));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind tmr3_regbank tmr3_regbank_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tmr3_regbank.sv
`timescale 1ns/1ps
module test_tmr3_regbank;
  localparam int AW = 8;
  localparam int CW = 16;

  logic          clk;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [47:0]   cnt_val, evt_val;
  logic [17:0]   irq_set;
  logic [17:0]   clk_ctrl, cnt_ctrl, irq_en;
  logic [47:0]   intv;
  logic [143:0]  match;
  logic [8:0]    evt_ctrl;
  logic [2:0]    cnt_rst, irq;

  int total = 0;
  int fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d;

  tmr3_regbank #(.ADDR_W(AW), .CNT_W(CW)) i_tmr3_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_val(cnt_val), .evt_val(evt_val),
    .irq_set(irq_set), .clk_ctrl(clk_ctrl), .cnt_ctrl(cnt_ctrl), .intv(intv),
    .match(match), .irq_en(irq_en), .evt_ctrl(evt_ctrl), .cnt_rst(cnt_rst),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each read strobe
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rst_n && rd_d && exp_q.size() > 0) begin
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_set(logic [AW-1:0] a, logic [31:0] e, int ch, logic [5:0] b, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a; irq_set[ch*6 +: 6] = b;
    @(negedge clk);
    rd_en = 1'b0; irq_set = '0;
  endtask

  task automatic pulse_set(int ch, logic [5:0] b);
    @(negedge clk);
    irq_set[ch*6 +: 6] = b;
    @(negedge clk);
    irq_set = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [335:0] snap;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    irq_set = '0;
    cnt_val = {16'h0007, 16'hBEEF, 16'h1234};
    evt_val = {16'h0C0D, 16'h0A0B, 16'h0102};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    @(negedge clk);
    check("R2 irq", 32'(irq), 32'h0);
    check("R2 cnt_ctrl port", 32'(cnt_ctrl), 32'({3{6'h21}}));
    rd(8'h0C, 32'h21, "R2 ctrl ch0");
    rd(8'h04, 32'h0, "R2 clk ch1");

    // R1 interleaved decode of compare value two
    wr(8'h3C, 32'h1111);
    wr(8'h40, 32'h2222);
    wr(8'h44, 32'h3333);
    rd(8'h3C, 32'h1111, "R1 match2 ch0");
    rd(8'h44, 32'h3333, "R1 match2 ch2");
    rd(8'h40, 32'h2222, "R1 match2 ch1");
    // R11 hold after the read
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, 32'h2222);
    check("R1 match port ch1 m2", 32'(match[(1*3+1)*16 +: 16]), 32'h2222);

    // R3 masking
    wr(8'h08, 32'hFFFF_FFFF);
    check("R3 clk port ch2", 32'(clk_ctrl[17:12]), 32'h3F);
    rd(8'h08, 32'h3F, "R3 clk ch2");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'hFFFF, "R3 intv ch1");
    wr(8'h48, 32'h1234_5678);
    rd(8'h48, 32'h5678, "R3 match3 ch0");
    wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h68, 32'h3F, "R3 ien ch2");
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h6C, 32'h7, "R3 ectl ch0");

    // R4 restart pulse
    wr(8'h10, 32'hFF);
    check("R4 pulse", 32'(cnt_rst), 32'b010);
    @(negedge clk);
    check("R4 pulse ends", 32'(cnt_rst), 32'b000);
    rd(8'h10, 32'h2F, "R3 ctrl ch1");

    // R5 live count, writes ignored
    rd(8'h1C, 32'hBEEF, "R5 val ch1");
    cnt_val[31:16] = 16'h0042;
    rd(8'h1C, 32'h0042, "R5 val ch1 live");
    wr(8'h18, 32'hAAAA);
    rd(8'h18, 32'h1234, "R5 val write ignored");

    // R6 event value
    rd(8'h80, 32'h0C0D, "R6 evt ch2");
    wr(8'h78, 32'h5555);
    rd(8'h78, 32'h0102, "R6 evt write ignored");

    // R7 latch and gate
    pulse_set(2, 6'b000010);
    check("R7 irq ch2", 32'(irq), 32'b100);
    pulse_set(0, 6'b000001);
    check("R7 irq ch0 gated", 32'(irq), 32'b100);

    // R8 clear on read
    rd(8'h5C, 32'h02, "R8 stat ch2");
    check("R8 irq ch2 cleared", 32'(irq), 32'b000);
    rd(8'h5C, 32'h00, "R8 stat ch2 empty");
    rd(8'h54, 32'h01, "R8 stat ch0 kept");
    pulse_set(1, 6'b001000);
    rd_set(8'h58, 32'h08, 1, 6'b100000, "R8 read with set");
    rd(8'h58, 32'h20, "R8 set kept");

    // R9 status writes ignored
    pulse_set(1, 6'b000100);
    wr(8'h58, 32'hFFFF_FFFF);
    rd(8'h58, 32'h04, "R9 stat write ignored");

    // R10 unmapped
    rd(8'h84, 32'h0, "R10 above window");
    rd(8'h31, 32'h0, "R10 misaligned");
    rd(8'hFC, 32'h0, "R10 top");
    snap = {clk_ctrl, cnt_ctrl, intv, match, irq_en, evt_ctrl, cnt_rst, irq};
    wr(8'h84, 32'hFFFF_FFFF);
    wr(8'h32, 32'hFFFF_FFFF);
    @(negedge clk);
    total++;
    if (snap !== {clk_ctrl, cnt_ctrl, intv, match, irq_en, evt_ctrl, cnt_rst, irq}) begin
      fails++;
      $display("FAIL R10 write unmapped: actual outputs changed expected unchanged");
    end
    rd(8'h30, 32'h0, "R10 match1 ch0 untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule